// File: doc/BRIEF.md
# Byte-Order-Preserving DMA Width Packer

This block sits inside one DMA channel, between a peripheral-side port that is always one word wide (32 bits by default) and a memory-side port whose unit can be 8, 16 or 32 bits. Whole peripheral words go into a small byte-addressed ring of four word slots (16 bytes). The memory side then takes them out as single bytes, halfwords or words. However the data is regrouped, the byte stream stays in strict little-endian order: the byte that arrived in bits [7:0] of the first word always leaves first.

Both sides use a ready/request handshake. The fill level is kept in bytes. Registered empty and full flags follow that level. A synchronous flush returns the block to its reset state in one cycle. Memory-side data is presented ahead of the request (show-ahead): whenever `pop_ready` is high, `pop_data` already holds the next unit. The memory unit size may change between pops, and the byte stream continues from wherever it stopped, even if the read point is then no longer aligned to the new size.

Top module: `dma_width_packer`

## Requirements
- R1: After reset, `level` is 0, `empty` is 1, `full` is 0, `push_ready` is 1 and `pop_ready` is 0.
- R2: `push_ready` is high exactly when `level` is at most 12 (one full 4-byte slot free). A push with `push_valid` high while `push_ready` is low changes neither the level nor the stored data.
- R3: `pop_ready` is high exactly when `level` is at least the current unit size in bytes. A `pop_req` while `pop_ready` is low changes neither the level nor the read position.
- R4: On each clock edge without flush, `level` rises by 4 for an accepted push and falls by the unit size for an accepted pop. Both can happen in the same cycle, and the level never exceeds 16.
- R5: `mem_size` selects the unit: 2'b00 is 1 byte, 2'b01 is 2 bytes, and both 2'b10 and 2'b11 are 4 bytes.
- R6: With a 1-byte unit, `pop_data[7:0]` is the oldest stored byte, in the order the bytes arrived (push_data[7:0] first, then [15:8], [23:16], [31:24] of each word), and `pop_data[31:8]` is zero.
- R7: With a 2-byte unit, `pop_data[7:0]` is the oldest byte, `pop_data[15:8]` is the next one, and `pop_data[31:16]` is zero.
- R8: With a 4-byte unit, `pop_data` holds the four oldest bytes, the oldest in [7:0]. A word pushed at an aligned position comes out unchanged.
- R9: `flush` has priority over push and pop in the same cycle. At the next edge it clears the level and both pointers, so `empty` is 1 afterwards and the next data out is the first byte pushed after the flush.
- R10: `empty` equals (`level` == 0) and `full` equals (`level` == 16) in every cycle. Both are registered.
- R11: Byte order holds across wraparound of the 16-byte ring and across changes of the unit size between pops, including reads that start at an unaligned byte position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of level and pointers |
| mem_size | input | 2 | Memory unit size code (00=1 byte, 01=2, 10/11=4) |
| push_valid | input | 1 | Peripheral side offers a word |
| push_data | input | 32 | Peripheral word, lowest-addressed byte in [7:0] |
| push_ready | output | 1 | A full word slot is free |
| pop_req | input | 1 | Memory side takes one unit |
| pop_data | output | 32 | Next unit, oldest byte in [7:0], unused bytes zero |
| pop_ready | output | 1 | At least one unit is stored |
| level | output | 5 | Fill level in bytes, 0 to 16 |
| empty | output | 1 | Level is zero |
| full | output | 1 | Level is 16 |

## Verification
A read pointer that advances by the wrong amount shows up on `pop_data` the next time `pop_ready` is high. Because the data is show-ahead, the stream then appears shifted or with a repeated byte within one cycle of the faulty pop. A wrong level first shows on `level`, `empty` or `full` right after the edge that updated it. Later it also shows as `push_ready` or `pop_ready` being high when the byte count says they should be low, or the other way round. A lane-select fault in the packing only appears for some unit sizes and read offsets. For that reason the random phase keeps switching the size while the read point is unaligned, and it wraps the ring many times.

// File: rtl/dwp_pkg.sv
package dwp_pkg;
   localparam logic [1:0] SIZE_BYTE = 2'b00;
   localparam logic [1:0] SIZE_HALF = 2'b01;
   localparam logic [1:0] SIZE_WORD = 2'b10;

   // unit size in bytes for a size code, capped by the memory port width
   function automatic int unsigned unit_bytes(input logic [1:0] code,
                                              input int unsigned max_bytes);
      int unsigned b;
      b = 32'd1 << code;
      if (b > max_bytes) b = max_bytes;
      return b;
   endfunction
endpackage

// File: rtl/dwp_store.sv
module dwp_store #(
   parameter int PB    = 4,
   parameter int SLOTS = 4,
   parameter int MB    = 4,
   localparam int DEPTH  = PB * SLOTS,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int LVL_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [8*PB-1:0]   wr_data,
   input  logic [PTR_W-1:0]  rd_ptr,
   input  logic [LVL_W-1:0]  rd_bytes,
   output logic [8*MB-1:0]   rd_data
);
   logic [8*DEPTH-1:0] flat;

   // one byte register per ring position; a push fills the lanes of one slot
   for (genvar i = 0; i < DEPTH; i++) begin : g_lane
      logic [7:0] byte_q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_slot == SLOT_W'(i / PB)))
            byte_q <= wr_data[8*(i % PB) +: 8];
      end
      assign flat[8*i +: 8] = byte_q;
   end

   // output lane k shows ring byte rd_ptr+k, zero beyond the unit size
   for (genvar k = 0; k < MB; k++) begin : g_out
      logic [PTR_W-1:0] idx;
      assign idx = rd_ptr + PTR_W'(k);
      assign rd_data[8*k +: 8] = (LVL_W'(k) < rd_bytes) ? flat[{idx, 3'b000} +: 8] : 8'h00;
   end
endmodule

// File: rtl/dwp_ctrl.sv
module dwp_ctrl #(
   parameter int PB    = 4,
   parameter int SLOTS = 4,
   parameter int MB    = 4,
   localparam int DEPTH  = PB * SLOTS,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int LVL_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [1:0]        size_code,
   input  logic              push_valid,
   input  logic              pop_req,
   output logic              push_ready,
   output logic              pop_ready,
   output logic              push_fire,
   output logic [SLOT_W-1:0] wr_slot,
   output logic [PTR_W-1:0]  rd_ptr,
   output logic [LVL_W-1:0]  unit,
   output logic [LVL_W-1:0]  level,
   output logic              empty,
   output logic              full
);
   logic             pop_fire;
   logic [LVL_W-1:0] lvl_nxt;

   assign unit       = LVL_W'(dwp_pkg::unit_bytes(size_code, MB));
   assign push_ready = (level <= LVL_W'(DEPTH - PB));
   assign pop_ready  = (level >= unit);
   assign push_fire  = push_valid & push_ready & ~flush;
   assign pop_fire   = pop_req & pop_ready & ~flush;

   always_comb begin
      lvl_nxt = level;
      if (push_fire) lvl_nxt = lvl_nxt + LVL_W'(PB);
      if (pop_fire)  lvl_nxt = lvl_nxt - unit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_slot <= '0;
         rd_ptr  <= '0;
         level   <= '0;
         empty   <= 1'b1;
         full    <= 1'b0;
      end else if (flush) begin
         wr_slot <= '0;
         rd_ptr  <= '0;
         level   <= '0;
         empty   <= 1'b1;
         full    <= 1'b0;
      end else begin
         if (push_fire) wr_slot <= wr_slot + SLOT_W'(1);
         if (pop_fire)  rd_ptr  <= rd_ptr + PTR_W'(unit);
         level <= lvl_nxt;
         empty <= (lvl_nxt == '0);
         full  <= (lvl_nxt == LVL_W'(DEPTH));
      end
   end
endmodule

// File: rtl/dma_width_packer.sv
module dma_width_packer #(
   parameter int PWIDTH = 32,
   parameter int MEM_W  = 32,
   parameter int SLOTS  = 4,
   localparam int PB    = PWIDTH / 8,
   localparam int MB    = MEM_W / 8,
   localparam int DEPTH = PB * SLOTS,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [1:0]        mem_size,
   input  logic              push_valid,
   input  logic [PWIDTH-1:0] push_data,
   output logic              push_ready,
   input  logic              pop_req,
   output logic [MEM_W-1:0]  pop_data,
   output logic              pop_ready,
   output logic [LVL_W-1:0]  level,
   output logic              empty,
   output logic              full
);
   if (PWIDTH % 8 != 0 || (PB & (PB - 1)) != 0) begin : g_bad_pwidth
      $error("PWIDTH must be a power-of-two number of bytes");
   end
   if (MEM_W % 8 != 0 || (MB & (MB - 1)) != 0 || MB > DEPTH) begin : g_bad_memw
      $error("MEM_W must be a power-of-two number of bytes not above the ring size");
   end
   if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("SLOTS must be a power of two of at least 2");
   end

   logic              push_fire;
   logic [SLOT_W-1:0] wr_slot;
   logic [PTR_W-1:0]  rd_ptr;
   logic [LVL_W-1:0]  unit;

   dwp_ctrl #(.PB(PB), .SLOTS(SLOTS), .MB(MB)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .size_code  (mem_size),
      .push_valid (push_valid),
      .pop_req    (pop_req),
      .push_ready (push_ready),
      .pop_ready  (pop_ready),
      .push_fire  (push_fire),
      .wr_slot    (wr_slot),
      .rd_ptr     (rd_ptr),
      .unit       (unit),
      .level      (level),
      .empty      (empty),
      .full       (full)
   );

   dwp_store #(.PB(PB), .SLOTS(SLOTS), .MB(MB)) u_store (
      .clk      (clk),
      .wr_en    (push_fire),
      .wr_slot  (wr_slot),
      .wr_data  (push_data),
      .rd_ptr   (rd_ptr),
      .rd_bytes (unit),
      .rd_data  (pop_data)
   );
endmodule

// File: rtl/dwp_checker.sv
module dwp_checker #(
   parameter int PWIDTH = 32,
   parameter int MEM_W  = 32,
   parameter int SLOTS  = 4,
   localparam int PB    = PWIDTH / 8,
   localparam int MB    = MEM_W / 8,
   localparam int DEPTH = PB * SLOTS,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush,
   input logic [1:0]       mem_size,
   input logic             push_valid,
   input logic             push_ready,
   input logic             pop_req,
   input logic             pop_ready,
   input logic [LVL_W-1:0] level,
   input logic             empty,
   input logic             full
);
   logic [LVL_W-1:0] chk_unit;
   logic             acc_push, acc_pop;
   assign chk_unit = LVL_W'(dwp_pkg::unit_bytes(mem_size, MB));
   assign acc_push = push_valid && push_ready && !flush;
   assign acc_pop  = pop_req && pop_ready && !flush;

   // R4
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH));

   // R10
   empty_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty == (level == '0));

   // R10
   full_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full == (level == LVL_W'(DEPTH)));

   // R9
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (level == '0) && empty && !full);

   // R4
   push_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_push && !acc_pop) |=> level == $past(level) + LVL_W'(PB));

   // R4
   pop_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_pop && !acc_push) |=> level == $past(level) - $past(chk_unit));

   // R2
   blocked_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && !push_ready && !flush && !acc_pop) |=> $stable(level));
endmodule

bind dma_width_packer dwp_checker #(.PWIDTH(PWIDTH), .MEM_W(MEM_W), .SLOTS(SLOTS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flush      (flush),
   .mem_size   (mem_size),
   .push_valid (push_valid),
   .push_ready (push_ready),
   .pop_req    (pop_req),
   .pop_ready  (pop_ready),
   .level      (level),
   .empty      (empty),
   .full       (full)
);

// File: tb/dma_width_packer_test.sv
module dma_width_packer_test;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic [1:0]  mem_size = 2'b00;
   logic        push_valid = 1'b0;
   logic [31:0] push_data = '0;
   logic        push_ready;
   logic        pop_req = 1'b0;
   logic [31:0] pop_data;
   logic        pop_ready;
   logic [4:0]  level;
   logic        empty;
   logic        full;

   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 0;
   string ctx = "";
   logic [7:0] mq[$];

   always #(CLK_P/2) clk = ~clk;

   dma_width_packer uut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .mem_size(mem_size),
      .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
      .pop_req(pop_req), .pop_data(pop_data), .pop_ready(pop_ready),
      .level(level), .empty(empty), .full(full));

   function automatic int exp_unit(input logic [1:0] sz);
      return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
   endfunction

   function automatic logic [31:0] exp_data(input int mb);
      logic [31:0] d = '0;
      for (int k = 0; k < mb; k++) d[8*k +: 8] = mq[k];
      return d;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // one cycle: drive at negedge, check show-ahead outputs, then state after the edge
   task automatic step(input bit pv, input logic [31:0] pd, input bit pr,
                       input logic [1:0] sz, input bit fl);
      int  mb;
      bit  e_pr, e_pu;
      string dtag;
      push_valid = pv; push_data = pd; pop_req = pr; mem_size = sz; flush = fl;
      #1;
      mb   = exp_unit(sz);
      e_pr = (mq.size() >= mb);
      e_pu = (mq.size() <= 12);
      check("R2 push_ready", 32'(push_ready), 32'(e_pu));
      check("R3 pop_ready", 32'(pop_ready), 32'(e_pr));
      if (e_pr) begin
         if (ctx != "")          dtag = ctx;
         else if (sz == 2'b00)   dtag = "R6 byte data";
         else if (sz == 2'b01)   dtag = "R7 half data";
         else if (sz == 2'b10)   dtag = "R8 word data";
         else                    dtag = "R5 size 11 data";
         check(dtag, pop_data, exp_data(mb));
      end
      if (fl) mq.delete();
      else begin
         if (pr && e_pr) for (int k = 0; k < mb; k++) void'(mq.pop_front());
         if (pv && e_pu) for (int k = 0; k < 4; k++) mq.push_back(pd[8*k +: 8]);
      end
      @(posedge clk);
      @(negedge clk);
      check(fl ? "R9 level after flush" : "R4 level", 32'(level), 32'(mq.size()));
      check("R10 empty", 32'(empty), 32'(mq.size() == 0));
      check("R10 full", 32'(full), 32'(mq.size() == 16));
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung, expected finished run");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 level", 32'(level), 0);
      check("R1 empty", 32'(empty), 1);
      check("R1 full", 32'(full), 0);
      check("R1 push_ready", 32'(push_ready), 1);
      check("R1 pop_ready", 32'(pop_ready), 0);
      @(negedge clk);

      // fill to full with bytes 00..0F, then a refused push (R2)
      for (int w = 0; w < 4; w++)
         step(1, {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)}, 0, 2'b00, 0);
      step(1, 32'hDEADBEEF, 0, 2'b00, 0);
      // pop with the wrong size never mind: request while empty is ignored later (R3)
      for (int i = 0; i < 8; i++) step(0, 0, 1, 2'b00, 0);
      for (int i = 0; i < 4; i++) step(0, 0, 1, 2'b01, 0);
      step(0, 0, 1, 2'b10, 0);
      // word pass-through and size code 11 (R8, R5)
      step(1, 32'hA3A2A1A0, 0, 2'b10, 0);
      step(1, 32'hB3B2B1B0, 1, 2'b10, 0);
      step(0, 0, 1, 2'b11, 0);
      // flush wins over a simultaneous push and pop (R9)
      step(1, 32'h11223344, 0, 2'b00, 0);
      step(1, 32'h55667788, 1, 2'b00, 1);
      step(1, 32'hC3C2C1C0, 0, 2'b00, 0);
      step(0, 0, 1, 2'b00, 0);
      step(0, 0, 1, 2'b00, 1);
      // unaligned reads across a size change and ring wrap (R11)
      ctx = "R11 order across wrap/size change";
      for (int w = 0; w < 3; w++) step(1, 32'h10203040 + 32'(w), 0, 2'b00, 0);
      step(0, 0, 1, 2'b00, 0);
      step(1, 32'hE3E2E1E0, 1, 2'b01, 0);
      step(1, 32'hF3F2F1F0, 1, 2'b10, 0);
      for (int i = 0; i < 10; i++) step(i % 2 == 0, 32'h0A0B0C0D ^ 32'(i), 1, 2'(i % 3), 0);
      ctx = "";

      // random phase
      for (int i = 0; i < 5000; i++) begin
         logic [1:0] sz;
         sz = ($urandom % 6 == 0) ? 2'($urandom) : mem_size;
         step(($urandom % 4) != 0, $urandom, ($urandom % 3) != 0, sz, ($urandom % 80) == 0);
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule